// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block hangs off an 8-bit host bus and offers three 8-bit ports, A, B and C, and a control register that can only be written. The host picks a register with a 2-bit address and uses chip select, read and write strobes. Each port pin is modelled as a separate input bit, output bit and output-enable bit, so the block can sit behind ordinary I/O buffers.

Ports A and B run in one of two modes. In basic mode each is a plain input or output port. In strobed mode each works as a one-byte mailbox with a handshake. Some port C pins then become the strobe, acknowledge, buffer-full and interrupt lines of that port. Port C is split into two 4-bit halves, and each half has its own direction. A control write whose top bit is clear sets or clears a single port C latch bit. This is also how software sets the interrupt enables of strobed ports. All pins are assumed to be synchronous to the clock. Strobe and acknowledge edges are detected by comparing each clock sample with the one taken before it.

Top module: `ppio_top`

## Requirements
- R1: After reset all output enables are 0, ports A and B are inputs in basic mode, both port C halves are inputs, every latch and handshake flag is 0, and rdata is 0x00.
- R2: Register select is addr 00 for port A, 01 for port B, 10 for port C and 11 for control. A write with cs=1 and wr=1 updates the addressed register. A read with cs=1 and rd=1 loads rdata on that clock edge, and the control address reads as 0x00.
- R3: In basic mode, a port or port C half set as output drives its latch with all of its enables set to 1. A port or half set as input drives no enables, and a read returns its input pins.
- R4: A control write with bit 7 set is a mode word. The bit meanings are: bits 6:5 nonzero puts A in strobed mode; bit 4 makes A an input; bit 3 makes C[7:4] an input; bit 2 puts B in strobed mode; bit 1 makes B an input; bit 0 makes C[3:0] an input. The write clears the A, B and C output latches and every buffer-full and interrupt flag.
- R5: A control write with bit 7 clear sets C latch bit wdata[3:1] to wdata[0], for example 0x09 sets bit 4. It changes no other latch bit and does not change the mode.
- R6: In strobed input mode, the port samples its pins when its strobe falls. The strobe is pc_in[4] for A and pc_in[2] for B, and both are active low. The falling edge also sets input-buffer-full, driven high on pc_out[5] for A and pc_out[1] for B. A read of the port returns the captured byte and clears the flag.
- R7: In strobed input mode, a rising strobe edge while the buffer is full sets the interrupt flag if the enable is 1. The enable is C latch bit 4 for A and bit 2 for B. The interrupt drives pc_out[3] for A and pc_out[0] for B, and a read of the port clears it.
- R8: In strobed output mode, a host write of the port drives the byte on the port pins and sets output-buffer-full. This flag shows active low on pc_out[7] for A and pc_out[1] for B. A falling edge of the acknowledge input clears it; the acknowledge is pc_in[6] for A and pc_in[2] for B.
- R9: In strobed output mode, a rising acknowledge edge sets the interrupt flag if the enable is 1. The enable is C latch bit 6 for A and bit 2 for B. The interrupt uses the same pins as in R7, and a host write of the port clears it.
- R10: Port C pins not used for handshake keep their half's basic direction. A port C read returns the driven value on driven pins, the latch bit on strobe and acknowledge pins, and the input pin on the others.
- R11: With cs=0, read and write strobes have no effect on any register or on rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Host read strobe |
| wr | input | 1 | Host write strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Registered host read data |
| pa_in | input | 8 | Port A pin inputs |
| pa_out | output | 8 | Port A pin outputs |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin inputs |
| pb_out | output | 8 | Port B pin outputs |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin inputs |
| pc_out | output | 8 | Port C pin outputs |
| pc_oe | output | 8 | Port C output enables |

## Verification
The assertions check on every cycle the effect of each handshake edge and host access on the buffer-full and interrupt flags, and that a mode word clears state. They also check that a single-bit command touches at most one latch bit and never the mode, and that a deselected bus leaves rdata alone. How the port C pins are shared out per mode, what a read returns in each mode, and the order of full mailbox exchanges on both ports can only be shown by the bench scenarios. The bench compares these against its reference model on every clock.

// File: rtl/ppio_pkg.sv
package ppio_pkg;

  localparam int PORT_W = 8;

  localparam logic [1:0] SEL_A   = 2'd0;
  localparam logic [1:0] SEL_B   = 2'd1;
  localparam logic [1:0] SEL_C   = 2'd2;
  localparam logic [1:0] SEL_CTL = 2'd3;

  typedef struct packed {
    logic a_stb;
    logic a_in;
    logic cu_in;
    logic b_stb;
    logic b_in;
    logic cl_in;
  } mode_t;

  localparam mode_t MODE_RST = '{a_stb: 1'b0, a_in: 1'b1, cu_in: 1'b1,
                                 b_stb: 1'b0, b_in: 1'b1, cl_in: 1'b1};

endpackage

// File: rtl/ppio_regs.sv
module ppio_regs
  import ppio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [1:0]        addr,
  input  logic [PORT_W-1:0] wdata,
  output mode_t             mode,
  output logic [PORT_W-1:0] pc_lat,
  output logic              mode_wr
);

  localparam int IDX_W = $clog2(PORT_W);

  logic ctl_wr;
  logic bit_cmd;

  assign ctl_wr  = host_wr && (addr == SEL_CTL);
  assign mode_wr = ctl_wr && wdata[7];
  assign bit_cmd = ctl_wr && !wdata[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= MODE_RST;
    end else if (mode_wr) begin
      mode.a_stb <= wdata[6] | wdata[5];
      mode.a_in  <= wdata[4];
      mode.cu_in <= wdata[3];
      mode.b_stb <= wdata[2];
      mode.b_in  <= wdata[1];
      mode.cl_in <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || mode_wr) begin
      pc_lat <= '0;
    end else if (host_wr && (addr == SEL_C)) begin
      pc_lat <= wdata;
    end else if (bit_cmd) begin
      pc_lat[wdata[IDX_W:1]] <= wdata[0];
    end
  end

  // R5: a single-bit command keeps the mode and flips at most one latch bit
  a_r5_single_bit: assert property (@(posedge clk) disable iff (rst)
    bit_cmd |=> ($stable(mode) && ($countones(pc_lat ^ $past(pc_lat)) <= 1)));

endmodule

// File: rtl/ppio_hs_chan.sv
module ppio_hs_chan #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          strobed,
  input  logic          is_in,
  input  logic          inte,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pins,
  input  logic          hs_pin,
  output logic [DW-1:0] out_lat,
  output logic [DW-1:0] in_lat,
  output logic          buf_full,
  output logic          irq
);

  logic hs_q;
  logic hs_fall;
  logic hs_rise;
  logic irq_q;
  logic stb_in;
  logic stb_out;

  assign hs_fall = hs_q && !hs_pin;
  assign hs_rise = !hs_q && hs_pin;
  assign stb_in  = strobed && is_in;
  assign stb_out = strobed && !is_in;
  assign irq     = irq_q && inte;

  always_ff @(posedge clk) begin
    if (rst) hs_q <= 1'b1;
    else     hs_q <= hs_pin;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)   out_lat <= '0;
    else if (host_wr) out_lat <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)                    in_lat <= '0;
    else if (stb_in && hs_fall) in_lat <= pins;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      buf_full <= 1'b0;
    end else if (stb_in) begin
      if (hs_fall)      buf_full <= 1'b1;
      else if (host_rd) buf_full <= 1'b0;
    end else if (stb_out) begin
      if (host_wr)      buf_full <= 1'b1;
      else if (hs_fall) buf_full <= 1'b0;
    end else begin
      buf_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      irq_q <= 1'b0;
    end else if (stb_in) begin
      if (hs_rise && buf_full && inte) irq_q <= 1'b1;
      else if (host_rd)                irq_q <= 1'b0;
    end else if (stb_out) begin
      if (hs_rise && inte) irq_q <= 1'b1;
      else if (host_wr)    irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
    end
  end

  // R6: a falling strobe captures the pins and fills the buffer
  a_r6_capture_on_strobe: assert property (@(posedge clk) disable iff (rst)
    (stb_in && !clr && hs_q && !hs_pin) |=> (buf_full && (in_lat == $past(pins))));

  // R6: without a strobe edge the captured byte holds
  a_r6_capture_holds: assert property (@(posedge clk) disable iff (rst)
    !(stb_in && hs_q && !hs_pin) |=> $stable(in_lat));

  // R8: a host write in output mode marks the buffer full
  a_r8_obf_on_write: assert property (@(posedge clk) disable iff (rst)
    (stb_out && !clr && host_wr) |=> buf_full);

  // R9: a host write in output mode drops a pending interrupt
  a_r9_write_clears_irq: assert property (@(posedge clk) disable iff (rst)
    (stb_out && host_wr && !(!hs_q && hs_pin)) |=> !irq_q);

  // R4: a mode word clears the output latch and both flags
  a_r4_clear_state: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!buf_full && !irq_q && (out_lat == '0)));

endmodule

// File: rtl/ppio_top.sv
module ppio_top
  import ppio_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cs,
  input  logic       rd,
  input  logic       wr,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] pa_in,
  output logic [7:0] pa_out,
  output logic [7:0] pa_oe,
  input  logic [7:0] pb_in,
  output logic [7:0] pb_out,
  output logic [7:0] pb_oe,
  input  logic [7:0] pc_in,
  output logic [7:0] pc_out,
  output logic [7:0] pc_oe
);

  localparam int NCH = 2;
  localparam int HALF = PORT_W / 2;

  logic        host_wr;
  logic        host_rd;
  mode_t       mode;
  logic [7:0]  pc_lat;
  logic        mode_wr;

  logic [NCH-1:0] ch_stb, ch_in, ch_inte, ch_wr, ch_rd, ch_hs, ch_bf, ch_irq;
  logic [PORT_W-1:0] ch_pins [NCH];
  logic [PORT_W-1:0] ch_out  [NCH];
  logic [PORT_W-1:0] ch_inl  [NCH];
  logic [7:0]  hs_in_mask;
  logic [7:0]  pc_rd;

  assign host_wr = cs && wr;
  assign host_rd = cs && rd;

  ppio_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .host_wr (host_wr),
    .addr    (addr),
    .wdata   (wdata),
    .mode    (mode),
    .pc_lat  (pc_lat),
    .mode_wr (mode_wr)
  );

  assign ch_stb  = {mode.b_stb, mode.a_stb};
  assign ch_in   = {mode.b_in, mode.a_in};
  assign ch_inte = {pc_lat[2], (mode.a_in ? pc_lat[4] : pc_lat[6])};
  assign ch_hs   = {pc_in[2], (mode.a_in ? pc_in[4] : pc_in[6])};
  assign ch_wr   = {host_wr && (addr == SEL_B), host_wr && (addr == SEL_A)};
  assign ch_rd   = {host_rd && (addr == SEL_B), host_rd && (addr == SEL_A)};
  assign ch_pins[0] = pa_in;
  assign ch_pins[1] = pb_in;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    ppio_hs_chan #(.DW(PORT_W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .clr      (mode_wr),
      .strobed  (ch_stb[g]),
      .is_in    (ch_in[g]),
      .inte     (ch_inte[g]),
      .host_wr  (ch_wr[g]),
      .host_rd  (ch_rd[g]),
      .wdata    (wdata),
      .pins     (ch_pins[g]),
      .hs_pin   (ch_hs[g]),
      .out_lat  (ch_out[g]),
      .in_lat   (ch_inl[g]),
      .buf_full (ch_bf[g]),
      .irq      (ch_irq[g])
    );
  end

  assign pa_out = ch_out[0];
  assign pb_out = ch_out[1];
  assign pa_oe  = {PORT_W{!mode.a_in}};
  assign pb_oe  = {PORT_W{!mode.b_in}};

  always_comb begin
    pc_out     = pc_lat;
    pc_oe      = {{HALF{!mode.cu_in}}, {HALF{!mode.cl_in}}};
    hs_in_mask = '0;
    if (mode.a_stb) begin
      pc_oe[3]  = 1'b1;
      pc_out[3] = ch_irq[0];
      if (mode.a_in) begin
        pc_oe[4]      = 1'b0;
        hs_in_mask[4] = 1'b1;
        pc_oe[5]      = 1'b1;
        pc_out[5]     = ch_bf[0];
      end else begin
        pc_oe[6]      = 1'b0;
        hs_in_mask[6] = 1'b1;
        pc_oe[7]      = 1'b1;
        pc_out[7]     = !ch_bf[0];
      end
    end
    if (mode.b_stb) begin
      pc_oe[0]      = 1'b1;
      pc_out[0]     = ch_irq[1];
      pc_oe[1]      = 1'b1;
      pc_out[1]     = mode.b_in ? ch_bf[1] : !ch_bf[1];
      pc_oe[2]      = 1'b0;
      hs_in_mask[2] = 1'b1;
    end
  end

  assign pc_rd = (pc_oe & pc_out) | (~pc_oe & hs_in_mask & pc_lat) |
                 (~pc_oe & ~hs_in_mask & pc_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (host_rd) begin
      case (addr)
        SEL_A:   rdata <= !mode.a_in ? ch_out[0] : (mode.a_stb ? ch_inl[0] : pa_in);
        SEL_B:   rdata <= !mode.b_in ? ch_out[1] : (mode.b_stb ? ch_inl[1] : pb_in);
        SEL_C:   rdata <= pc_rd;
        default: rdata <= '0;
      endcase
    end
  end

  // R11: a deselected bus leaves the read register untouched
  a_r11_no_select: assert property (@(posedge clk) disable iff (rst)
    !cs |=> $stable(rdata));

  // R10: strobe and acknowledge inputs are never driven
  a_r10_hs_inputs_undriven: assert property (@(posedge clk) disable iff (rst)
    (mode.b_stb |-> !pc_oe[2]));

endmodule

// File: tb/ppio_top_tb.sv
module ppio_top_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'hFF;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    checking = 1'b0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  ppio_top u_dut (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  // reference model state
  bit m_ast, m_ain, m_cuin, m_bst, m_bin, m_clin;
  bit [7:0] m_pa, m_pb, m_pc, m_ina, m_inb, m_rdata;
  bit m_bfa, m_bfb, m_ia, m_ib, m_prev_a, m_prev_b;

  function automatic bit inte_a();
    return m_ain ? m_pc[4] : m_pc[6];
  endfunction

  function automatic bit [7:0] exp_pc_oe();
    bit [7:0] oe;
    oe = {{4{!m_cuin}}, {4{!m_clin}}};
    if (m_ast) begin
      oe[3] = 1;
      if (m_ain) begin oe[4] = 0; oe[5] = 1; end
      else begin oe[6] = 0; oe[7] = 1; end
    end
    if (m_bst) begin oe[0] = 1; oe[1] = 1; oe[2] = 0; end
    return oe;
  endfunction

  function automatic bit [7:0] exp_pc_val();
    bit [7:0] v;
    v = m_pc;
    if (m_ast) begin
      v[3] = m_ia && inte_a();
      if (m_ain) v[5] = m_bfa; else v[7] = !m_bfa;
    end
    if (m_bst) begin
      v[0] = m_ib && m_pc[2];
      v[1] = m_bin ? m_bfb : !m_bfb;
    end
    return v;
  endfunction

  function automatic bit [7:0] model_read(input bit [1:0] a);
    bit [7:0] oe, r;
    case (a)
      2'd0: return !m_ain ? m_pa : (m_ast ? m_ina : pa_in);
      2'd1: return !m_bin ? m_pb : (m_bst ? m_inb : pb_in);
      2'd2: begin
        oe = exp_pc_oe();
        for (int i = 0; i < 8; i++) begin
          if (oe[i]) r[i] = exp_pc_val() >> i;
          else if ((m_ast && m_ain && i == 4) || (m_ast && !m_ain && i == 6) ||
                   (m_bst && i == 2)) r[i] = m_pc[i];
          else r[i] = pc_in[i];
        end
        return r;
      end
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      {m_ast, m_bst} = 2'b00;
      {m_ain, m_cuin, m_bin, m_clin} = 4'hF;
      m_pa = 0; m_pb = 0; m_pc = 0; m_ina = 0; m_inb = 0; m_rdata = 0;
      {m_bfa, m_bfb, m_ia, m_ib} = 4'h0;
      m_prev_a = 1; m_prev_b = 1;
    end else begin
      automatic bit pin_a = m_ain ? pc_in[4] : pc_in[6];
      automatic bit pin_b = pc_in[2];
      automatic bit fa = m_prev_a && !pin_a, ra = !m_prev_a && pin_a;
      automatic bit fb = m_prev_b && !pin_b, rb = !m_prev_b && pin_b;
      automatic bit wa = cs && wr && addr == 0, wb = cs && wr && addr == 1;
      automatic bit rda = cs && rd && addr == 0, rdb = cs && rd && addr == 1;
      automatic bit ea = inte_a(), eb = m_pc[2];
      automatic bit nbfa = m_bfa, nbfb = m_bfb, nia = m_ia, nib = m_ib;
      if (cs && rd) m_rdata = model_read(addr);
      // port A flags
      if (!m_ast) begin nbfa = 0; nia = 0; end
      else if (m_ain) begin
        if (fa) begin nbfa = 1; m_ina = pa_in; end else if (rda) nbfa = 0;
        if (ra && m_bfa && ea) nia = 1; else if (rda) nia = 0;
      end else begin
        if (wa) nbfa = 1; else if (fa) nbfa = 0;
        if (ra && ea) nia = 1; else if (wa) nia = 0;
      end
      // port B flags
      if (!m_bst) begin nbfb = 0; nib = 0; end
      else if (m_bin) begin
        if (fb) begin nbfb = 1; m_inb = pb_in; end else if (rdb) nbfb = 0;
        if (rb && m_bfb && eb) nib = 1; else if (rdb) nib = 0;
      end else begin
        if (wb) nbfb = 1; else if (fb) nbfb = 0;
        if (rb && eb) nib = 1; else if (wb) nib = 0;
      end
      m_bfa = nbfa; m_bfb = nbfb; m_ia = nia; m_ib = nib;
      m_prev_a = pin_a; m_prev_b = pin_b;
      if (wa) m_pa = wdata;
      if (wb) m_pb = wdata;
      if (cs && wr && addr == 2) m_pc = wdata;
      if (cs && wr && addr == 3) begin
        if (wdata[7]) begin
          m_ast = wdata[6] | wdata[5]; m_ain = wdata[4]; m_cuin = wdata[3];
          m_bst = wdata[2]; m_bin = wdata[1]; m_clin = wdata[0];
          m_pa = 0; m_pb = 0; m_pc = 0;
          {m_bfa, m_bfb, m_ia, m_ib} = 4'h0;
        end else begin
          m_pc[wdata[3:1]] = wdata[0];
        end
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (checking) begin
      chk({cur_req, " pa_oe"}, pa_oe, {8{!m_ain}});
      chk({cur_req, " pa_out"}, pa_out & pa_oe, m_pa & {8{!m_ain}});
      chk({cur_req, " pb_oe"}, pb_oe, {8{!m_bin}});
      chk({cur_req, " pb_out"}, pb_out & pb_oe, m_pb & {8{!m_bin}});
      chk({cur_req, " pc_oe"}, pc_oe, exp_pc_oe());
      chk({cur_req, " pc_out"}, pc_out & pc_oe, exp_pc_val() & exp_pc_oe());
      chk({cur_req, " rdata"}, rdata, m_rdata);
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input logic sel = 1'b1);
    tick(); cs = sel; wr = 1; addr = a; wdata = d;
    tick(); cs = 0; wr = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    tick(); cs = 1; rd = 1; addr = a;
    tick(); cs = 0; rd = 0; d = rdata;
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) tick();
    rst = 0;
    tick();
    checking = 1;
    // R1: reset state
    cur_req = "R1";
    chk("R1 pa_oe", pa_oe, 8'h00);
    chk("R1 pc_oe", pc_oe, 8'h00);
    chk("R1 rdata", rdata, 8'h00);
    // R11: deselected write to control and deselected read
    cur_req = "R11";
    bus_wr(2'd3, 8'h80, 1'b0);
    tick();
    chk("R11 pa_oe", pa_oe, 8'h00);
    pb_in = 8'h44;
    tick(); cs = 0; rd = 1; addr = 2'd1; tick(); rd = 0;
    chk("R11 rdata", rdata, 8'h00);
    // R4/R3/R2: all outputs in basic mode
    cur_req = "R3";
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd0, 8'h5A);
    bus_wr(2'd1, 8'hC3);
    bus_wr(2'd2, 8'h96);
    chk("R3 pa_out", pa_out, 8'h5A);
    chk("R3 pa_oe", pa_oe, 8'hFF);
    chk("R3 pc_out", pc_out, 8'h96);
    cur_req = "R2";
    bus_rd(2'd0, d); chk("R2 read A", d, 8'h5A);
    bus_rd(2'd3, d); chk("R2 read ctl", d, 8'h00);
    // R4: mode word clears latches; A input, C upper input
    cur_req = "R4";
    bus_wr(2'd3, 8'h98);
    chk("R4 pb cleared", pb_out, 8'h00);
    chk("R4 pc_oe", pc_oe, 8'h0F);
    chk("R4 pc cleared", pc_out & pc_oe, 8'h00);
    cur_req = "R3";
    pa_in = 8'h3C; pc_in = 8'hA5;
    bus_rd(2'd0, d); chk("R3 read A pins", d, 8'h3C);
    bus_rd(2'd2, d); chk("R3 read C halves", d, 8'hA0);
    // R5: single-bit commands
    cur_req = "R5";
    bus_wr(2'd3, 8'h07);
    chk("R5 set bit3", pc_out, 8'h08);
    bus_wr(2'd3, 8'h03);
    chk("R5 set bit1", pc_out, 8'h0A);
    bus_wr(2'd3, 8'h06);
    chk("R5 clear bit3", pc_out, 8'h02);
    chk("R5 mode kept", pc_oe, 8'h0F);
    // R6/R7: strobed input on both ports
    cur_req = "R6";
    pc_in = 8'hFF;
    bus_wr(2'd3, 8'hB6);
    bus_wr(2'd3, 8'h09);
    bus_wr(2'd3, 8'h05);
    pa_in = 8'hA5; pb_in = 8'h1E;
    tick(); pc_in[4] = 0; pc_in[2] = 0;
    tick();
    chk("R6 ibf A", {7'd0, pc_out[5]}, 8'h01);
    chk("R6 ibf B", {7'd0, pc_out[1]}, 8'h01);
    pa_in = 8'hFF; pb_in = 8'h00;
    cur_req = "R7";
    pc_in[4] = 1; pc_in[2] = 1;
    tick();
    chk("R7 irq A", {7'd0, pc_out[3]}, 8'h01);
    chk("R7 irq B", {7'd0, pc_out[0]}, 8'h01);
    cur_req = "R10";
    bus_rd(2'd2, d); chk("R10 read C status", d, 8'h3F);
    cur_req = "R6";
    bus_rd(2'd0, d); chk("R6 read A latched", d, 8'hA5);
    chk("R6 ibf A cleared", {7'd0, pc_out[5]}, 8'h00);
    chk("R7 irq A cleared", {7'd0, pc_out[3]}, 8'h00);
    bus_rd(2'd1, d); chk("R6 read B latched", d, 8'h1E);
    // R7: no interrupt when enable is clear
    cur_req = "R7";
    bus_wr(2'd3, 8'h08);
    tick(); pc_in[4] = 0; tick(); pc_in[4] = 1; tick();
    chk("R7 irq A masked", {7'd0, pc_out[3]}, 8'h00);
    // R8/R9: strobed output on both ports
    cur_req = "R8";
    bus_wr(2'd3, 8'hA4);
    bus_wr(2'd3, 8'h0D);
    bus_wr(2'd3, 8'h05);
    bus_wr(2'd0, 8'h77);
    chk("R8 pa drive", pa_out, 8'h77);
    chk("R8 obf A low", {7'd0, pc_out[7]}, 8'h00);
    bus_wr(2'd1, 8'h88);
    chk("R8 obf B low", {7'd0, pc_out[1]}, 8'h00);
    tick(); pc_in[6] = 0; pc_in[2] = 0;
    tick();
    chk("R8 obf A released", {7'd0, pc_out[7]}, 8'h01);
    chk("R8 obf B released", {7'd0, pc_out[1]}, 8'h01);
    cur_req = "R9";
    pc_in[6] = 1; pc_in[2] = 1;
    tick();
    chk("R9 irq A", {7'd0, pc_out[3]}, 8'h01);
    chk("R9 irq B", {7'd0, pc_out[0]}, 8'h01);
    bus_wr(2'd0, 8'h12);
    chk("R9 irq A cleared", {7'd0, pc_out[3]}, 8'h00);
    cur_req = "R10";
    chk("R10 free C bits", pc_oe & 8'h30, 8'h30);
    repeat (3) tick();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule